// File: doc/BRIEF.md
# Banked Dual-Write-Port Memory

This block is a memory with two independent write ports and one read port, assembled from four simple banks. Each bank has one write port and one read port. The two lowest address bits pick a bank, so each bank stores a quarter of the address space. When the two writes fall in different banks, both finish in the same clock. That gives a peak of two writes per cycle without copying the storage.

When both writes land in the same bank, only one can be taken. The winner is fixed: port 0 by default. The losing port sees its stall output high for that cycle, and its write does not touch memory. The requester on that port keeps its address, data and enable steady until the stall drops. The write then goes through on a later cycle.

The read port is synchronous and returns data one clock after the address is presented. Forwarding registers give write-first behaviour: a read of an address that an accepted write updates in the same cycle returns the new value.

Top module: `bkram_dualwr`

## Requirements
- R1: Address bits [1:0] select one of four banks, and a value written at any address is returned by a later read of that same address, across the full 256-entry space.
- R2: Two enabled writes whose address bits [1:0] differ both complete in the same cycle, and neither stall output is high.
- R3: Two enabled writes whose address bits [1:0] are equal (same address included) form a conflict: write port 1 stall is high in that cycle, write port 0 stall stays low, and the port 0 write completes.
- R4: A write whose stall output is high has no effect on memory in that cycle; a read of its address in that cycle returns the previous contents.
- R5: A stall output is never high when only one write port is enabled, or when none is.
- R6: Read data for the address presented before a rising clock edge appears on rd_data after that edge, one cycle of latency.
- R7: A read of an address that an accepted write (from either port) updates in the same cycle returns the newly written data.
- R8: The read output mux uses registered address bits [1:0], so rd_data does not change when rd_addr changes between clock edges.
- R9: A stalled port 1 write that is held stable is accepted, with its stall low, in the first cycle in which it no longer shares a bank with an enabled port 0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | ADDR_W | Write port 0 address |
| wr0_data | input | DATA_W | Write port 0 data |
| wr0_stall | output | 1 | Port 0 write not accepted this cycle |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | ADDR_W | Write port 1 address |
| wr1_data | input | DATA_W | Write port 1 data |
| wr1_stall | output | 1 | Port 1 write not accepted this cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |

## Verification
Two functions can fall in the same cycle: a bank conflict between the write ports, and a read aimed at the address of one of those writes. The bench provokes both at once. It reads the stalled port 1 address while the conflict is in progress and expects the old value. It reads the winning port 0 address and expects the forwarded new value. A flat reference array applies only the writes the requirements say are accepted, so the read data and each stall bit are judged against it in the same cycle.

// File: rtl/bkram_pkg.sv
package bkram_pkg;

  localparam int NUM_WPORTS = 2;

  typedef enum logic {
    WPORT0 = 1'b0,
    WPORT1 = 1'b1
  } wport_e;

endpackage

// File: rtl/bkram_bank.sv
module bkram_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  // Plain storage with no reset, one write and one registered read, so it
  // maps onto a simple dual-port block RAM. Reads return the old contents.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bkram_arb.sv
module bkram_arb #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int PRIO_PORT = 0,
  localparam int NB       = 1 << BANK_BITS,
  localparam int IDX_W    = ADDR_W - BANK_BITS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 wen,
  input  logic [1:0][ADDR_W-1:0]     waddr,
  input  logic [1:0][DATA_W-1:0]     wdata,
  output logic [1:0]                 stall,
  output logic [1:0]                 accept,
  output logic [NB-1:0]              bk_we,
  output logic [NB-1:0][IDX_W-1:0]   bk_waddr,
  output logic [NB-1:0][DATA_W-1:0]  bk_wdata
);

  localparam int WIN  = PRIO_PORT;
  localparam int LOSE = 1 - PRIO_PORT;

  logic [BANK_BITS-1:0] bsel0, bsel1;
  logic                 conflict;

  assign bsel0    = waddr[0][BANK_BITS-1:0];
  assign bsel1    = waddr[1][BANK_BITS-1:0];
  assign conflict = wen[0] && wen[1] && (bsel0 == bsel1);

  always_comb begin
    stall       = '0;
    stall[LOSE] = conflict;
    stall[WIN]  = 1'b0;
  end

  assign accept = wen & ~stall;

  // Route each accepted write into the bank selected by its low bits.
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bk_we[b]    = 1'b0;
      bk_waddr[b] = waddr[0][ADDR_W-1:BANK_BITS];
      bk_wdata[b] = wdata[0];
      if (accept[1] && (bsel1 == BANK_BITS'(b))) begin
        bk_we[b]    = 1'b1;
        bk_waddr[b] = waddr[1][ADDR_W-1:BANK_BITS];
        bk_wdata[b] = wdata[1];
      end
      if (accept[0] && (bsel0 == BANK_BITS'(b))) begin
        bk_we[b]    = 1'b1;
        bk_waddr[b] = waddr[0][ADDR_W-1:BANK_BITS];
        bk_wdata[b] = wdata[0];
      end
    end
  end

  // R2: a bank never receives two writes, so both ports cannot be
  // accepted into one bank.
  p_bank_single_src_r2: assert property (@(posedge clk) disable iff (rst)
    (accept == 2'b11) |-> (bsel0 != bsel1));

  // R3: the priority port is never stalled.
  p_winner_free_r3: assert property (@(posedge clk) disable iff (rst)
    wen[WIN] |-> accept[WIN]);

endmodule

// File: rtl/bkram_fwd.sv
module bkram_fwd #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [1:0]             accept,
  input  logic [1:0][ADDR_W-1:0] waddr,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0]      bank_rdata,
  output logic [DATA_W-1:0]      rd_data
);

  logic              hit0, hit1;
  logic              hit_q;
  logic [DATA_W-1:0] fwd_q;

  assign hit0 = accept[0] && (waddr[0] == rd_addr);
  assign hit1 = accept[1] && (waddr[1] == rd_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      fwd_q <= '0;
    end else begin
      hit_q <= hit0 || hit1;
      if (hit0) begin
        fwd_q <= wdata[0];
      end else if (hit1) begin
        fwd_q <= wdata[1];
      end
    end
  end

  assign rd_data = hit_q ? fwd_q : bank_rdata;

  // R7: two accepted writes never share one address, so at most one
  // forwarding source matches the read.
  p_single_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    !(hit0 && hit1));

endmodule

// File: rtl/bkram_dualwr.sv
module bkram_dualwr #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int PRIO_PORT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_addr,
  input  logic [DATA_W-1:0] wr0_data,
  output logic              wr0_stall,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_addr,
  input  logic [DATA_W-1:0] wr1_data,
  output logic              wr1_stall,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import bkram_pkg::*;

  localparam int NB    = 1 << BANK_BITS;
  localparam int IDX_W = ADDR_W - BANK_BITS;

  logic [NUM_WPORTS-1:0]              wen, stall, accept;
  logic [NUM_WPORTS-1:0][ADDR_W-1:0]  waddr;
  logic [NUM_WPORTS-1:0][DATA_W-1:0]  wdata;
  logic [NB-1:0]                      bk_we;
  logic [NB-1:0][IDX_W-1:0]           bk_waddr;
  logic [NB-1:0][DATA_W-1:0]          bk_wdata;
  logic [NB-1:0][DATA_W-1:0]          bk_rdata;
  logic [BANK_BITS-1:0]               rsel_q;
  logic [DATA_W-1:0]                  bank_mux;

  assign wen[WPORT0]   = wr0_en;
  assign wen[WPORT1]   = wr1_en;
  assign waddr[WPORT0] = wr0_addr;
  assign waddr[WPORT1] = wr1_addr;
  assign wdata[WPORT0] = wr0_data;
  assign wdata[WPORT1] = wr1_data;
  assign wr0_stall     = stall[WPORT0];
  assign wr1_stall     = stall[WPORT1];

  bkram_arb #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BANK_BITS(BANK_BITS), .PRIO_PORT(PRIO_PORT)
  ) u_arb (
    .clk(clk), .rst(rst),
    .wen(wen), .waddr(waddr), .wdata(wdata),
    .stall(stall), .accept(accept),
    .bk_we(bk_we), .bk_waddr(bk_waddr), .bk_wdata(bk_wdata)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bkram_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk),
      .we(bk_we[b]),
      .waddr(bk_waddr[b]),
      .wdata(bk_wdata[b]),
      .raddr(rd_addr[ADDR_W-1:BANK_BITS]),
      .rdata(bk_rdata[b])
    );
  end

  // Bank select is registered alongside the bank read so the mux lines up
  // with the one-cycle read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= '0;
    end else begin
      rsel_q <= rd_addr[BANK_BITS-1:0];
    end
  end

  assign bank_mux = bk_rdata[rsel_q];

  bkram_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .clk(clk), .rst(rst),
    .rd_addr(rd_addr), .accept(accept),
    .waddr(waddr), .wdata(wdata),
    .bank_rdata(bank_mux), .rd_data(rd_data)
  );

  // R5: any stall needs both ports requesting.
  p_stall_needs_both_r5: assert property (@(posedge clk) disable iff (rst)
    (wr0_stall || wr1_stall) |-> (wr0_en && wr1_en));

  // R3: a conflict stalls exactly one port.
  p_one_stall_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr0_stall && wr1_stall));

  // R7: write-first for port 0.
  p_write_first0_r7: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && !wr0_stall && (wr0_addr == rd_addr)) |=> (rd_data == $past(wr0_data)));

  // R7: write-first for port 1.
  p_write_first1_r7: assert property (@(posedge clk) disable iff (rst)
    (wr1_en && !wr1_stall && (wr1_addr == rd_addr)) |=> (rd_data == $past(wr1_data)));

  // R9: once port 0 goes idle, a held port 1 write is taken.
  p_retry_taken_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(wr1_stall) && wr1_en && !wr0_en) |-> !wr1_stall);

endmodule

// File: tb/sim_bkram_dualwr.sv
`timescale 1ns/1ps
module sim_bkram_dualwr;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 14;
  localparam int VW = 1 + AW + DW + 1 + AW + DW + AW + 1;

  // Fields: we0, a0, d0, we1, a1, d1, ra, expected port 1 stall.
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 8'h10, 16'hAAAA, 1'b1, 8'h21, 16'hBBBB, 8'h10, 1'b0},
    {1'b1, 8'h33, 16'h1234, 1'b1, 8'h33, 16'h5678, 8'h33, 1'b1},
    {1'b1, 8'h04, 16'hC0DE, 1'b1, 8'h08, 16'hFACE, 8'h08, 1'b1},
    {1'b0, 8'h00, 16'h0000, 1'b1, 8'h08, 16'hFACE, 8'h08, 1'b0},
    {1'b0, 8'h00, 16'h0000, 1'b1, 8'h3F, 16'h7777, 8'h3F, 1'b0},
    {1'b1, 8'h80, 16'h1111, 1'b0, 8'h00, 16'h0000, 8'h81, 1'b0},
    {1'b1, 8'hFF, 16'h2222, 1'b1, 8'hFE, 16'h3333, 8'hFE, 1'b0},
    {1'b1, 8'hFD, 16'h4444, 1'b1, 8'hF9, 16'h5555, 8'hF9, 1'b1},
    {1'b1, 8'hF1, 16'h6666, 1'b1, 8'hF9, 16'h5555, 8'hF1, 1'b1},
    {1'b0, 8'h00, 16'h0000, 1'b1, 8'hF9, 16'h5555, 8'hF9, 1'b0},
    {1'b0, 8'h00, 16'h0000, 1'b0, 8'h00, 16'h0000, 8'h04, 1'b0},
    {1'b1, 8'h02, 16'h9999, 1'b1, 8'h03, 16'h8888, 8'h03, 1'b0},
    {1'b0, 8'h00, 16'h0000, 1'b0, 8'h00, 16'h0000, 8'h02, 1'b0},
    {1'b1, 8'hC1, 16'hAB00, 1'b1, 8'hC5, 16'hCD00, 8'hC1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          wr0_en, wr1_en;
  logic [AW-1:0] wr0_addr, wr1_addr, rd_addr;
  logic [DW-1:0] wr0_data, wr1_data, rd_data;
  logic          wr0_stall, wr1_stall;

  logic [DW-1:0] ref_mem [256];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done  = 0;

  always #2 clk = ~clk;

  bkram_dualwr u0 (
    .clk(clk), .rst(rst),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data), .wr0_stall(wr0_stall),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data), .wr1_stall(wr1_stall),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge; drives one cycle, checks the stall bits,
  // then checks read data at the next falling edge.
  task automatic cycle(input logic we0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic we1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input logic [AW-1:0] ra, input logic es1, input string tag);
    logic          same;
    logic          acc1;
    logic [DW-1:0] exp_rd;
    wr0_en = we0; wr0_addr = a0; wr0_data = d0;
    wr1_en = we1; wr1_addr = a1; wr1_data = d1;
    rd_addr = ra;
    #1;
    same = we0 && we1 && (a0[1:0] == a1[1:0]);
    acc1 = we1 && !same;
    check({tag, " stall1"}, 32'(wr1_stall), 32'(es1));
    check({tag, " stall1-model"}, 32'(wr1_stall), 32'(same));
    check("R3 stall0 low", 32'(wr0_stall), 32'd0);
    @(posedge clk);
    if (acc1) ref_mem[a1] = d1;
    if (we0)  ref_mem[a0] = d0;
    exp_rd = ref_mem[ra];
    @(negedge clk);
    check({tag, " rd_data"}, 32'(rd_data), 32'(exp_rd));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    wr0_en = 0; wr1_en = 0; wr0_addr = 0; wr1_addr = 0;
    wr0_data = 0; wr1_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    // Reset state: idle ports show no stall (R5).
    check("R5 reset stall0", 32'(wr0_stall), 32'd0);
    check("R5 reset stall1", 32'(wr1_stall), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2: fill all addresses two per cycle in distinct banks, reading
    // the port 0 address (write-first, R7).
    for (int i = 0; i < 128; i++) begin
      cycle(1'b1, AW'(2 * i), DW'({8'(2 * i), 8'(2 * i) ^ 8'h5A}),
            1'b1, AW'(2 * i + 1), DW'({8'(2 * i + 1), 8'(2 * i + 1) ^ 8'h5A}),
            AW'(2 * i), 1'b0, "R2 fill");
    end
    // R1: read back every address through the bank mux (R6 latency).
    for (int i = 0; i < 256; i++) begin
      cycle(1'b0, '0, '0, 1'b0, '0, '0, AW'(i), 1'b0, "R1 readback");
    end

    // Vector table: conflicts (R3), stalled write ignored (R4),
    // single port (R5), retry (R9), write-first (R7).
    for (int v = 0; v < NV; v++) begin
      cycle(VEC[v][58], VEC[v][57:50], VEC[v][49:34],
            VEC[v][33], VEC[v][32:25], VEC[v][24:9],
            VEC[v][8:1], VEC[v][0], "R3/R4/R9 table");
    end

    // R4 directed: stalled port 1 write, read of its address gives old data.
    cycle(1'b1, 8'h50, 16'hE000, 1'b1, 8'h54, 16'hE111, 8'h54, 1'b1, "R4");
    check("R4 old value kept", 32'(rd_data), {16'h0, 8'h54, 8'h54 ^ 8'h5A});
    // R9 directed: port 0 moves to another bank, held port 1 write goes in.
    cycle(1'b1, 8'h51, 16'hE222, 1'b1, 8'h54, 16'hE111, 8'h54, 1'b0, "R9");
    check("R9 retried data", 32'(rd_data), 32'h0000E111);

    // R7 port 1 write-first with port 0 busy elsewhere.
    cycle(1'b1, 8'h60, 16'h0F0F, 1'b1, 8'h63, 16'hF0F0, 8'h63, 1'b0, "R7");
    check("R7 port1 forward", 32'(rd_data), 32'h0000F0F0);

    // R6: read of a fixed address, value appears right after the edge.
    cycle(1'b0, '0, '0, 1'b0, '0, '0, 8'h60, 1'b0, "R6");
    check("R6 latency", 32'(rd_data), 32'h00000F0F);

    // R8: change rd_addr mid-cycle to another bank; output holds.
    rd_addr = 8'h63;
    #1;
    check("R8 output held", 32'(rd_data), 32'h00000F0F);
    @(posedge clk);
    @(negedge clk);
    check("R8 next read", 32'(rd_data), 32'h0000F0F0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule